// File: doc/BRIEF.md
# Descending Word Stack Engine over a Byte Memory

The engine sits between a 16-bit register path and a memory that moves one byte at a time. It keeps the stack pointer and moves whole 16-bit words onto and off a stack that grows toward lower addresses. It handles every word the same way, whether the word is a general register, a segment value or a flag word. Each memory byte goes to a physical byte address. That address is the stack segment input shifted left four places, plus a 16-bit offset taken from the stack pointer.

A push stores the two bytes of a word, most significant byte first, just below the current pointer. A pop fetches the byte at the pointer as the low half and the byte above it as the high half. Every byte transfer is a request that stays on the memory port until the memory acknowledges it. The pointer moves by two only after both bytes are done, and a one-cycle completion pulse marks the end of each word. While an operation is in flight the engine reports busy and ignores new requests.

Top module: `stack_word_engine`

## Requirements
- R1: While `rst` is high at a rising edge the engine returns to idle and loads `sp` from `sp_init`. After that edge `busy`, `done` and `mem_req` are 0.
- R2: A push of word W with pointer P makes two write transfers (`mem_we`=1), in this order: W[15:8] to offset P-1, then W[7:0] to offset P-2.
- R3: A pop with pointer P makes two read transfers (`mem_we`=0), in this order: from offset P, then from offset P+1. In the cycle `done` is high, `pop_data` holds the first byte in bits [7:0] and the second byte in bits [15:8].
- R4: `sp` drops by 2 after a push and rises by 2 after a pop, both modulo 2^16. It takes its new value in the cycle `done` is high and does not change at any other time.
- R5: `mem_addr` = (segment × 16 + offset) modulo 2^20. The offset is computed modulo 2^16 before the segment is added. The segment is `stack_seg` as sampled in the cycle the request is accepted.
- R6: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values. A byte transfer ends only on a cycle with `mem_ack` high.
- R7: `busy` is high from the cycle after a request is accepted until `done`. Requests seen while `busy` is high are ignored and leave `sp` and the memory port unaffected.
- R8: `done` is high for exactly one cycle: the cycle after the acknowledge of the second byte.
- R9: An idle engine accepts a request on the edge where it sees it. If `push_req` and `pop_req` are high together, the push wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sp_init | input | 16 | Pointer value loaded on reset |
| stack_seg | input | 16 | Stack segment base, sampled at accept |
| push_req | input | 1 | Start a word push (idle only) |
| pop_req | input | 1 | Start a word pop (idle only) |
| push_data | input | 16 | Word to push, sampled at accept |
| pop_data | output | 16 | Assembled pop result, valid with `done` |
| sp | output | 16 | Current stack pointer |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, taken when `mem_ack` is high |
| mem_ack | input | 1 | Memory completes the current transfer |

## Verification
The assertions check properties that hold on every cycle. Port signals stay stable while the memory stalls. `done` never lasts two cycles. The pointer stays still while the engine is idle. A write acknowledge leads either to the second write or to completion. A request accepted from idle starts a transfer whose direction follows the push-first priority. Only the bench scenarios can show the actual address values and the data round trip. These include wrap of the offset and of the 20-bit address, holding the segment through a mid-operation change of `stack_seg`, dropped requests during `busy`, and reset in the middle of an operation.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } stk_state_t;
endpackage

// File: rtl/stk_offset_calc.sv
module stk_offset_calc #(
    parameter int OFS_W = 16
) (
    input  logic [OFS_W-1:0] sp_cur,
    input  logic             is_push,
    input  logic             second,
    output logic [OFS_W-1:0] ofs
);
    // push: high byte below pointer, then low byte two below
    // pop : byte at pointer, then byte above it
    always_comb begin
        case ({is_push, second})
            2'b10:   ofs = sp_cur - OFS_W'(1);
            2'b11:   ofs = sp_cur - OFS_W'(2);
            2'b01:   ofs = sp_cur + OFS_W'(1);
            default: ofs = sp_cur;
        endcase
    end
endmodule

// File: rtl/stk_phys_addr.sv
module stk_phys_addr #(
    parameter int OFS_W     = 16,
    parameter int SEG_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int ADDR_W   = SEG_W + SEG_SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] addr
);
    generate
        if (SEG_SHIFT == 0) begin : g_flat
            assign addr = ADDR_W'(seg) + ADDR_W'(ofs);
        end else begin : g_shift
            assign addr = {seg, {SEG_SHIFT{1'b0}}} + ADDR_W'(ofs);
        end
    endgenerate
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int SEG_W  = 16,
    localparam int BYTE_W = OFS_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  sp_init,
    input  logic [SEG_W-1:0]  seg_in,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [OFS_W-1:0]  push_data,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              in_first,
    output logic              is_push,
    output logic [OFS_W-1:0]  sp_cur,
    output logic [SEG_W-1:0]  seg_lat,
    output logic [OFS_W-1:0]  word,
    output logic              done
);
    typedef struct packed {
        stk_state_t       state;
        logic             push;
        logic [OFS_W-1:0] sp;
        logic [SEG_W-1:0] seg;
        logic [OFS_W-1:0] word;
        logic             done;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (push_req || pop_req) begin
                    r_d.state = ST_FIRST;
                    r_d.push  = push_req;
                    r_d.seg   = seg_in;
                    if (push_req) begin
                        r_d.word = push_data;
                    end
                end
            end
            ST_FIRST: begin
                if (mem_ack) begin
                    if (!r_q.push) begin
                        r_d.word[BYTE_W-1:0] = mem_rdata;
                    end
                    r_d.state = ST_SECOND;
                end
            end
            ST_SECOND: begin
                if (mem_ack) begin
                    if (!r_q.push) begin
                        r_d.word[OFS_W-1:BYTE_W] = mem_rdata;
                    end
                    r_d.sp    = r_q.push ? r_q.sp - OFS_W'(2) : r_q.sp + OFS_W'(2);
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_IDLE;
            r_q.push  <= 1'b0;
            r_q.sp    <= sp_init;
            r_q.seg   <= '0;
            r_q.word  <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.state != ST_IDLE);
    assign in_first = (r_q.state == ST_FIRST);
    assign is_push  = r_q.push;
    assign sp_cur   = r_q.sp;
    assign seg_lat  = r_q.seg;
    assign word     = r_q.word;
    assign done     = r_q.done;

    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        r_q.done |=> !r_q.done);

    // R4: pointer does not drift while idle with no request
    assert_sp_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_IDLE && !push_req && !pop_req) |=> $stable(r_q.sp));
endmodule

// File: rtl/stack_word_engine.sv
module stack_word_engine #(
    parameter int OFS_W     = 16,
    parameter int SEG_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int ADDR_W   = SEG_W + SEG_SHIFT,
    localparam int BYTE_W   = OFS_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  sp_init,
    input  logic [SEG_W-1:0]  stack_seg,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [OFS_W-1:0]  push_data,
    output logic [OFS_W-1:0]  pop_data,
    output logic [OFS_W-1:0]  sp,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic             in_first;
    logic             is_push;
    logic [SEG_W-1:0] seg_lat;
    logic [OFS_W-1:0] word;
    logic [OFS_W-1:0] ofs;

    stk_ctrl #(.OFS_W(OFS_W), .SEG_W(SEG_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sp_init   (sp_init),
        .seg_in    (stack_seg),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .push_data (push_data),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .in_first  (in_first),
        .is_push   (is_push),
        .sp_cur    (sp),
        .seg_lat   (seg_lat),
        .word      (word),
        .done      (done)
    );

    stk_offset_calc #(.OFS_W(OFS_W)) u_ofs (
        .sp_cur  (sp),
        .is_push (is_push),
        .second  (!in_first),
        .ofs     (ofs)
    );

    stk_phys_addr #(.OFS_W(OFS_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT)) u_addr (
        .seg  (seg_lat),
        .ofs  (ofs),
        .addr (mem_addr)
    );

    assign mem_req   = busy;
    assign mem_we    = busy && is_push;
    assign mem_wdata = in_first ? word[OFS_W-1:BYTE_W] : word[BYTE_W-1:0];
    assign pop_data  = word;

    // R6: a stalled transfer keeps its address, direction and data
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R2: an acknowledged write is followed by the second write or completion
    assert_write_order_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack) |=> (done || (mem_req && mem_we)));

    // R9: an idle request starts at once, push taking priority
    assert_start_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && (push_req || pop_req)) |=> (mem_req && (mem_we == $past(push_req))));
endmodule

// File: tb/test_stack_word_engine.sv
module test_stack_word_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] sp_init = 16'hABCD;
    logic [15:0] stack_seg = 16'h0000;
    logic        push_req = 1'b0;
    logic        pop_req = 1'b0;
    logic [15:0] push_data = 16'h0000;
    logic [15:0] pop_data;
    logic [15:0] sp;
    logic        busy, done, mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] mem [logic [19:0]];
    logic [15:0] exp_sp;

    always #4 clk = ~clk;

    stack_word_engine i_stack_word_engine (
        .clk(clk), .rst(rst), .sp_init(sp_init), .stack_seg(stack_seg),
        .push_req(push_req), .pop_req(pop_req), .push_data(push_data),
        .pop_data(pop_data), .sp(sp), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        int unsigned v;
        v = (int'(s) * 16) + int'(o);
        return v[19:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Runs one word operation; memory answers after 'waits' stall cycles.
    task automatic run_op(input bit psh, input bit both, input logic [15:0] w,
                          input int waits, input bit scramble, input bit poke,
                          output logic [15:0] got);
        logic [19:0] a [2];
        logic [7:0]  d [2];
        logic        we [2];
        logic [15:0] seg0, sp0;
        seg0 = stack_seg;
        sp0  = exp_sp;
        push_req  = psh | both;
        pop_req   = !psh | both;
        push_data = w;
        @(negedge clk);
        push_req = 1'b0;
        pop_req  = 1'b0;
        if (scramble) stack_seg = seg0 ^ 16'h5A5A;
        for (int b = 0; b < 2; b++) begin
            chk("R7 busy during op", busy, 1);
            a[b] = mem_addr; we[b] = mem_we; d[b] = mem_wdata;
            for (int k = 0; k < waits; k++) begin
                if (poke && b == 0 && k == 0) begin
                    push_req = 1'b1; pop_req = 1'b1; push_data = ~w;
                end
                @(negedge clk);
                push_req = 1'b0; pop_req = 1'b0;
                chk("R6 req held", mem_req, 1);
                chk("R6 addr held", mem_addr, a[b]);
                chk("R6 we held", mem_we, we[b]);
                chk("R6 data held", mem_wdata, d[b]);
            end
            mem_ack = 1'b1;
            if (mem_we) mem[mem_addr] = mem_wdata;
            else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
            @(negedge clk);
            mem_ack = 1'b0;
        end
        chk("R8 done after second ack", done, 1);
        chk("R7 busy clear at done", busy, 0);
        got = pop_data;
        if (psh) begin
            chk("R2 first write", we[0], 1);
            chk("R2 second write", we[1], 1);
            chk("R2 R5 high byte addr", a[0], phys(seg0, sp0 - 16'd1));
            chk("R2 R5 low byte addr", a[1], phys(seg0, sp0 - 16'd2));
            chk("R2 high byte first", d[0], w[15:8]);
            chk("R2 low byte second", d[1], w[7:0]);
            exp_sp = sp0 - 16'd2;
        end else begin
            chk("R3 first read", we[0], 0);
            chk("R3 second read", we[1], 0);
            chk("R3 R5 low byte addr", a[0], phys(seg0, sp0));
            chk("R3 R5 high byte addr", a[1], phys(seg0, sp0 + 16'd1));
            exp_sp = sp0 + 16'd2;
        end
        chk("R4 sp step", sp, exp_sp);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);
        stack_seg = seg0;
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                chk("R7 ignored request no transfer", mem_req, 0);
                chk("R7 ignored request sp", sp, exp_sp);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R8 watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] sps [7];
        logic [15:0] segs [4];
        logic [15:0] got, w;
        int n;
        sps  = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'hFFFF, 16'hFFFE, 16'h1234};
        segs = '{16'h0000, 16'hFFFF, 16'h8001, 16'h1000};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 sp reset value", sp, 16'hABCD);
        chk("R1 busy reset", busy, 0);
        chk("R1 done reset", done, 0);
        chk("R1 mem_req reset", mem_req, 0);
        exp_sp = 16'hABCD;

        n = 0;
        foreach (segs[si]) begin
            foreach (sps[pi]) begin
                stack_seg = segs[si];
                sp_init = sps[pi];
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                exp_sp = sps[pi];
                chk("R1 sp reload", sp, exp_sp);
                w = 16'h1000 * 16'(si) + 16'h0101 * 16'(pi) + 16'h8C3B;
                run_op(1'b1, 1'b0, w, n % 3, 1'b0, 1'b0, got);
                run_op(1'b0, 1'b0, 16'h0000, (n + 1) % 3, 1'b0, 1'b0, got);
                chk("R3 pop round trip", got, w);
                n++;
            end
        end

        // two stacked words pop back in reverse order
        exp_sp = sp;
        run_op(1'b1, 1'b0, 16'hA1B2, 1, 1'b0, 1'b0, got);
        run_op(1'b1, 1'b0, 16'hC3D4, 0, 1'b0, 1'b0, got);
        run_op(1'b0, 1'b0, 16'h0000, 2, 1'b0, 1'b0, got);
        chk("R3 last pushed first", got, 16'hC3D4);
        run_op(1'b0, 1'b0, 16'h0000, 0, 1'b0, 1'b0, got);
        chk("R3 earlier word second", got, 16'hA1B2);

        // segment change mid-operation has no effect on addresses
        stack_seg = 16'h2345;
        run_op(1'b1, 1'b0, 16'h5566, 2, 1'b1, 1'b0, got);
        run_op(1'b0, 1'b0, 16'h0000, 1, 1'b1, 1'b0, got);
        chk("R5 latched segment round trip", got, 16'h5566);

        // simultaneous request: push wins
        run_op(1'b1, 1'b1, 16'h7788, 1, 1'b0, 1'b0, got);
        run_op(1'b0, 1'b0, 16'h0000, 0, 1'b0, 1'b0, got);
        chk("R9 push priority data", got, 16'h7788);

        // requests during busy are dropped
        run_op(1'b1, 1'b0, 16'h99AA, 2, 1'b0, 1'b1, got);
        run_op(1'b0, 1'b0, 16'h0000, 2, 1'b0, 1'b1, got);
        chk("R7 word unaffected by dropped request", got, 16'h99AA);

        // reset in the middle of an operation
        push_req = 1'b1; push_data = 16'hDEAD;
        @(negedge clk);
        push_req = 1'b0;
        chk("R7 busy before reset", busy, 1);
        sp_init = 16'h4242;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 idle after mid-op reset", busy, 0);
        chk("R1 no request after mid-op reset", mem_req, 0);
        chk("R1 sp after mid-op reset", sp, 16'h4242);
        @(negedge clk);
        chk("R1 stays idle", mem_req, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule